// File: doc/BRIEF.md
# Dual Indirect Address Pointer Unit

This block keeps two 9-bit pointers, A and B, into the 512-word register RAM of a small pipelined processor. The addresses are absolute and bypass any per-task register remapping. Decode steers updates to one pointer or the other by a select bit. An update can come from an early pipeline stage as a set, increment or decrement command with an immediate value. It can also come from a late stage as a load from a register operand, with either a constant added to the operand or the operand shifted left by a constant.

An early-stage update shows on the pointer output in the cycle after it is issued. A register-sourced load is issued together with its operand and is held in a short internal pipeline. It shows on the output in the third cycle after issue. Each pointer steps inside its own base/limit window. Because of this, a region of register RAM can serve as a circular buffer: a producer writes through A, and a consumer reads through B. A compare command records whether the two pointers are equal in a zero flag. This gives a single-step empty test for that buffer.

Top module: `ind_ptr_unit`

## Requirements
- R1: While reset is held, and after it is released, both pointers read 0, the zero flag reads 0, and both windows span base 0 to limit 511.
- R2: An early-stage command with op code 2'b00 (set) loads the immediate into the selected pointer, and the output shows it in the next cycle. Op code 2'b11 leaves the pointer unchanged.
- R3: Op code 2'b01 (increment) adds one to the selected pointer. When the pointer is at or above its window limit, the pointer becomes the window base instead.
- R4: Op code 2'b10 (decrement) subtracts one from the selected pointer. When the pointer is at or below its window base, the pointer becomes the window limit instead.
- R5: A register load issued in cycle t changes the output in cycle t+3. The outputs in cycles t+1 and t+2 are not affected by the load.
- R6: With load mode 0 (add), the loaded value is the low 9 bits of the operand plus the 9-bit constant, so the sum wraps modulo 512.
- R7: With load mode 1 (shift), the loaded value is the low 9 bits of the operand shifted left by the low 4 bits of the constant. A constant of 0 loads the operand unchanged.
- R8: When a delayed load lands in the same cycle as an early-stage command to the same pointer, the load value wins. A command issued together with the load still shows for the two cycles before the load lands.
- R9: A window write sets the base and limit of the selected pointer only, and leaves both pointer values unchanged. The base must not exceed the limit. A step in the same cycle as a window write uses the old window.
- R10: A compare command sets the zero flag in the next cycle to 1 if A equals B as they stood in the compare cycle, and to 0 otherwise. Without a compare command the flag holds its value.
- R11: A command aimed at one pointer (select 0 = A, select 1 = B) never changes the other pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| win_we_i | input | 1 | Window write strobe |
| win_sel_i | input | 1 | Window target, 0 = A, 1 = B |
| win_base_i | input | 9 | New window base |
| win_limit_i | input | 9 | New window limit |
| cst_valid_i | input | 1 | Early-stage command valid |
| cst_sel_i | input | 1 | Early-stage target, 0 = A, 1 = B |
| cst_op_i | input | 2 | 00 set, 01 increment, 10 decrement, 11 none |
| cst_imm_i | input | 9 | Immediate for set |
| ld_valid_i | input | 1 | Register load issue |
| ld_sel_i | input | 1 | Load target, 0 = A, 1 = B |
| ld_mode_i | input | 1 | 0 add constant, 1 shift left by constant |
| ld_opnd_i | input | 32 | Register operand |
| ld_const_i | input | 9 | Load constant (shift uses low 4 bits) |
| cmp_i | input | 1 | Compare A with B into the zero flag |
| ptr_a_o | output | 9 | Pointer A |
| ptr_b_o | output | 9 | Pointer B |
| zero_o | output | 1 | Pointer-equality flag |

## Verification
The bench checks wrap at both ends of a narrow window. A design that compared with the wrong bound would run past the limit, or would stick at the base. It counts the exact load latency, so that a delay stage too many or too few moves the change one cycle off the expected slot. It makes a landing load collide with an early command to the same pointer, which exposes a reversed priority. It also tests add overflow and shift-out of high operand bits, where a design that did not truncate correctly would load a wrong address. A long random run mixes window writes, both command kinds and compares on both pointers, and would reveal cross-talk between A and B or a zero flag that does not hold its value.

// File: rtl/ind_ptr_pkg.sv
package ind_ptr_pkg;
  localparam int unsigned ADDR_W = 9;
  typedef logic [ADDR_W-1:0] addr_t;

  typedef enum logic [1:0] {
    CST_SET = 2'b00,
    CST_INC = 2'b01,
    CST_DEC = 2'b10,
    CST_NOP = 2'b11
  } cst_op_e;

  typedef enum logic {
    LD_ADD = 1'b0,
    LD_SHL = 1'b1
  } ld_mode_e;

  typedef struct packed {
    logic  vld;
    logic  sel;
    addr_t val;
  } ld_req_t;
endpackage

// File: rtl/ind_ld_pipe.sv
module ind_ld_pipe
  import ind_ptr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LD_LAT = 2,
  parameter int unsigned SH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              sel_i,
  input  ld_mode_e          mode_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  addr_t             cst_i,
  output ld_req_t           req_o
);
  logic [DATA_W-1:0] sum_w, shl_w;
  addr_t             val_w;

  always_comb begin
    sum_w = opnd_i + DATA_W'(cst_i);
    shl_w = opnd_i << cst_i[SH_W-1:0];
    val_w = (mode_i == LD_SHL) ? shl_w[ADDR_W-1:0] : sum_w[ADDR_W-1:0];
  end

  ld_req_t stg_q [LD_LAT];

  genvar g;
  generate
    for (g = 0; g < LD_LAT; g++) begin : g_stg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          stg_q[g] <= '0;
        end else if (g == 0) begin
          stg_q[g] <= '{vld: vld_i, sel: sel_i, val: val_w};
        end else begin
          stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
        end
      end
    end
  endgenerate

  assign req_o = stg_q[LD_LAT-1];

  // R6: add-mode value captured into first stage
  assert_add_capture_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && mode_i == LD_ADD) |=> stg_q[0].val == addr_t'($past(opnd_i[ADDR_W-1:0]) + $past(cst_i)));
endmodule

// File: rtl/ind_ptr_reg.sv
module ind_ptr_reg
  import ind_ptr_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    win_we_i,
  input  addr_t   win_base_i,
  input  addr_t   win_limit_i,
  input  logic    cst_en_i,
  input  cst_op_e cst_op_i,
  input  addr_t   cst_imm_i,
  input  logic    ld_en_i,
  input  addr_t   ld_val_i,
  output addr_t   ptr_o
);
  addr_t ptr_q, base_q, limit_q, step_w, ptr_d;

  always_comb begin
    unique case (cst_op_i)
      CST_SET: step_w = cst_imm_i;
      CST_INC: step_w = (ptr_q >= limit_q) ? base_q  : ptr_q + addr_t'(1);
      CST_DEC: step_w = (ptr_q <= base_q)  ? limit_q : ptr_q - addr_t'(1);
      default: step_w = ptr_q;
    endcase
    ptr_d = ptr_q;
    if (cst_en_i) ptr_d = step_w;
    if (ld_en_i)  ptr_d = ld_val_i;  // late load overrides early command
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      base_q  <= '0;
      limit_q <= '1;
    end else begin
      ptr_q <= ptr_d;
      if (win_we_i) begin
        base_q  <= win_base_i;
        limit_q <= win_limit_i;
      end
    end
  end

  assign ptr_o = ptr_q;

  assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cst_en_i && cst_op_i == CST_SET && !ld_en_i) |=> ptr_q == $past(cst_imm_i));

  assert_inc_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cst_en_i && cst_op_i == CST_INC && !ld_en_i && ptr_q >= limit_q) |=> ptr_q == $past(base_q));

  assert_dec_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cst_en_i && cst_op_i == CST_DEC && !ld_en_i && ptr_q <= base_q) |=> ptr_q == $past(limit_q));

  assert_load_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_en_i |=> ptr_q == $past(ld_val_i));

  assert_window_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_we_i |-> win_base_i <= win_limit_i);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cst_en_i && !ld_en_i) |=> $stable(ptr_q));
endmodule

// File: rtl/ind_eq_flag.sv
module ind_eq_flag
  import ind_ptr_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cmp_i,
  input  addr_t ptr_a_i,
  input  addr_t ptr_b_i,
  output logic  zero_o
);
  logic zero_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    zero_q <= 1'b0;
    else if (cmp_i) zero_q <= (ptr_a_i == ptr_b_i);
  end

  assign zero_o = zero_q;

  assert_cmp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_i |=> zero_q == ($past(ptr_a_i) == $past(ptr_b_i)));

  assert_zero_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_i |=> $stable(zero_q));
endmodule

// File: rtl/ind_ptr_unit.sv
module ind_ptr_unit
  import ind_ptr_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LD_LAT = 2,
  parameter int unsigned SH_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_we_i,
  input  logic              win_sel_i,
  input  logic [8:0]        win_base_i,
  input  logic [8:0]        win_limit_i,
  input  logic              cst_valid_i,
  input  logic              cst_sel_i,
  input  logic [1:0]        cst_op_i,
  input  logic [8:0]        cst_imm_i,
  input  logic              ld_valid_i,
  input  logic              ld_sel_i,
  input  logic              ld_mode_i,
  input  logic [DATA_W-1:0] ld_opnd_i,
  input  logic [8:0]        ld_const_i,
  input  logic              cmp_i,
  output logic [8:0]        ptr_a_o,
  output logic [8:0]        ptr_b_o,
  output logic              zero_o
);
  localparam int unsigned N_PTR = 2;

  ld_req_t ld_req;
  addr_t   ptr [N_PTR];

  ind_ld_pipe #(
    .DATA_W(DATA_W),
    .LD_LAT(LD_LAT),
    .SH_W  (SH_W)
  ) u_ld_pipe (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .vld_i (ld_valid_i),
    .sel_i (ld_sel_i),
    .mode_i(ld_mode_e'(ld_mode_i)),
    .opnd_i(ld_opnd_i),
    .cst_i (ld_const_i),
    .req_o (ld_req)
  );

  genvar i;
  generate
    for (i = 0; i < N_PTR; i++) begin : g_ptr
      ind_ptr_reg u_ptr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .win_we_i   (win_we_i && (win_sel_i == 1'(i))),
        .win_base_i (win_base_i),
        .win_limit_i(win_limit_i),
        .cst_en_i   (cst_valid_i && (cst_sel_i == 1'(i))),
        .cst_op_i   (cst_op_e'(cst_op_i)),
        .cst_imm_i  (cst_imm_i),
        .ld_en_i    (ld_req.vld && (ld_req.sel == 1'(i))),
        .ld_val_i   (ld_req.val),
        .ptr_o      (ptr[i])
      );
    end
  endgenerate

  ind_eq_flag u_eq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmp_i  (cmp_i),
    .ptr_a_i(ptr[0]),
    .ptr_b_i(ptr[1]),
    .zero_o (zero_o)
  );

  assign ptr_a_o = ptr[0];
  assign ptr_b_o = ptr[1];

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |=> (ptr_a_o == '0 || rst_ni));
endmodule

// File: tb/tb_ind_ptr_unit.sv
module tb_ind_ptr_unit;
  localparam int DW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic win_we = 0, win_sel = 0, cst_valid = 0, cst_sel = 0, ld_valid = 0, ld_sel = 0, ld_mode = 0, cmp = 0;
  logic [8:0] win_base = 0, win_limit = 0, cst_imm = 0, ld_const = 0;
  logic [1:0] cst_op = 2'b11;
  logic [DW-1:0] ld_opnd = 0;
  logic [8:0] ptr_a, ptr_b;
  logic zero;

  always #2 clk = ~clk;

  ind_ptr_unit dut (
    .clk_i(clk), .rst_ni(rst_n),
    .win_we_i(win_we), .win_sel_i(win_sel), .win_base_i(win_base), .win_limit_i(win_limit),
    .cst_valid_i(cst_valid), .cst_sel_i(cst_sel), .cst_op_i(cst_op), .cst_imm_i(cst_imm),
    .ld_valid_i(ld_valid), .ld_sel_i(ld_sel), .ld_mode_i(ld_mode), .ld_opnd_i(ld_opnd),
    .ld_const_i(ld_const), .cmp_i(cmp),
    .ptr_a_o(ptr_a), .ptr_b_o(ptr_b), .zero_o(zero)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic done = 0;

  int m_ptr [2], m_base [2], m_lim [2];
  int m_z;
  typedef struct { int due; int sel; int val; } pend_t;
  pend_t q [$];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic clear_in();
    win_we = 0; cst_valid = 0; cst_op = 2'b11; ld_valid = 0; cmp = 0;
  endtask

  // reference step: applies the inputs currently driven, then compares
  task automatic step(string tag);
    int np [2];
    logic [DW-1:0] t;
    if (cmp) m_z = (m_ptr[0] == m_ptr[1]) ? 1 : 0;
    for (int i = 0; i < 2; i++) begin
      np[i] = m_ptr[i];
      if (cst_valid && int'(cst_sel) == i) begin
        case (cst_op)
          2'b00: np[i] = cst_imm;
          2'b01: np[i] = (m_ptr[i] >= m_lim[i]) ? m_base[i] : m_ptr[i] + 1;
          2'b10: np[i] = (m_ptr[i] <= m_base[i]) ? m_lim[i] : m_ptr[i] - 1;
          default: ;
        endcase
      end
    end
    for (int k = q.size() - 1; k >= 0; k--)
      if (q[k].due == cyc) begin np[q[k].sel] = q[k].val; q.delete(k); end
    if (win_we) begin m_base[win_sel] = win_base; m_lim[win_sel] = win_limit; end
    if (ld_valid) begin
      if (ld_mode) t = ld_opnd << ld_const[3:0];
      else         t = ld_opnd + DW'(ld_const);
      q.push_back('{due: cyc + 2, sel: int'(ld_sel), val: int'(t[8:0])});
    end
    m_ptr = np;
    @(posedge clk);
    cyc++;
    @(negedge clk);
    clear_in();
    chk(tag, "ptr_a", int'(ptr_a), m_ptr[0]);
    chk(tag, "ptr_b", int'(ptr_b), m_ptr[1]);
    chk(tag, "zero", int'(zero), m_z);
  endtask

  task automatic cst(int sel, logic [1:0] op, int imm);
    cst_valid = 1; cst_sel = sel[0]; cst_op = op; cst_imm = imm[8:0];
  endtask

  task automatic ld(int sel, logic mode, logic [DW-1:0] opnd, int c);
    ld_valid = 1; ld_sel = sel[0]; ld_mode = mode; ld_opnd = opnd; ld_const = c[8:0];
  endtask

  task automatic win(int sel, int b, int l);
    win_we = 1; win_sel = sel[0]; win_base = b[8:0]; win_limit = l[8:0];
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_ptr[i] = 0; m_base[i] = 0; m_lim[i] = 511; end
    m_z = 0;
    repeat (3) @(negedge clk);
    chk("R1", "ptr_a in reset", int'(ptr_a), 0);
    chk("R1", "zero in reset", int'(zero), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "ptr_a", int'(ptr_a), 0);
    chk("R1", "ptr_b", int'(ptr_b), 0);
    chk("R1", "zero", int'(zero), 0);
    // R1 full window: decrement from 0 goes to 511
    cst(0, 2'b10, 0); step("R1");
    chk("R1", "full window limit", int'(ptr_a), 511);
    cst(0, 2'b01, 0); step("R1");
    chk("R1", "full window wrap", int'(ptr_a), 0);

    win(0, 16, 19); step("R9");
    cst(0, 2'b00, 18); step("R2");
    chk("R2", "set visible next cycle", int'(ptr_a), 18);
    cst(0, 2'b11, 77); step("R2");
    cst(0, 2'b01, 0); step("R3");
    cst(0, 2'b01, 0); step("R3");
    chk("R3", "wrap to base", int'(ptr_a), 16);
    cst(0, 2'b10, 0); step("R4");
    chk("R4", "wrap to limit", int'(ptr_a), 19);
    cst(0, 2'b10, 0); step("R4");

    cst(1, 2'b00, 5); step("R11");
    chk("R11", "A untouched", int'(ptr_a), 18);
    cmp = 1; step("R10");
    cst(1, 2'b00, 18); step("R10");
    cmp = 1; step("R10");
    chk("R10", "equal flag", int'(zero), 1);
    step("R10");

    ld(0, 1'b0, 100, 7); step("R5");
    chk("R5", "t+1 unchanged", int'(ptr_a), 18);
    step("R5");
    chk("R5", "t+2 unchanged", int'(ptr_a), 18);
    step("R5");
    chk("R5", "t+3 loaded", int'(ptr_a), 107);
    ld(1, 1'b0, 510, 5); step("R6"); step("R6"); step("R6");
    chk("R6", "add wraps", int'(ptr_b), 3);
    ld(0, 1'b1, 3, 4); step("R7");
    ld(1, 1'b1, 32'hFFFF_FFFF, 1); step("R7");
    ld(0, 1'b1, 300, 0); step("R7");
    chk("R7", "shift 3<<4", int'(ptr_a), 48);
    step("R7");
    chk("R7", "shift truncates", int'(ptr_b), 510);
    step("R7");
    chk("R7", "shift zero plain", int'(ptr_a), 300);

    ld(1, 1'b0, 200, 0); cst(1, 2'b00, 9); step("R8");
    chk("R8", "early set shows", int'(ptr_b), 9);
    step("R8");
    cst(1, 2'b01, 0); step("R8");
    chk("R8", "load wins collision", int'(ptr_b), 200);

    for (int n = 0; n < 4000; n++) begin
      int s, b;
      s = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) begin
        b = $urandom_range(0, 511);
        win(s, b, $urandom_range(b, 511));
      end
      if ($urandom_range(0, 1) == 1) cst($urandom_range(0, 1), 2'($urandom_range(0, 3)), $urandom_range(0, 511));
      if ($urandom_range(0, 3) == 0) ld($urandom_range(0, 1), 1'($urandom_range(0, 1)), $urandom, $urandom_range(0, 511));
      if ($urandom_range(0, 3) == 0) cmp = 1;
      step("R11");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule